// File: doc/BRIEF.md
# PCI Bus Cycle Capture Qualifier

This block sits beside a 32-bit PCI bus as a passive observer. On every rising edge of the bus clock it samples the address/data lines, the byte enables and the handshake signals. It then decides whether that clock is worth a slot in a trace memory. When the sample is kept, the block raises a store strobe and presents the captured bus word, a tag that names the phase type, an auxiliary nibble and a timestamp. The auxiliary nibble is the bus command on address-type samples and a byte-lane validity mask on data samples. The trace memory, host readout and text decoding sit outside the block.

Three capture policies can be chosen with a two-bit mode input. Bus-cycle mode keeps only address phases and completed data phases. Dual-address mode also keeps the clock that follows each address phase, so that the upper half of a 64-bit address survives. Every-edge mode keeps every clock. A new mode is adopted only on a bus-idle clock, so one transaction is never split across two policies. The output is a plain valid strobe with no ready input, because a bus observer cannot stall the bus. The sink must accept a sample on every clock in which `st_valid` is high; any sample offered while the sink is busy is lost.

Top module: `pci_capture_qual`

## Requirements
- R1: Bus values present at rising edge k are reflected at the outputs after rising edge k+1, because the inputs and the outputs are both registered. `st_valid` is low while `rst_n` is low.
- R2: In mode 00 (and in the reserved mode 11), a sample is stored only for an address phase or for a completed data phase, which is a clock where IRDY#, TRDY# and DEVSEL# are all low. Wait and idle clocks are not stored.
- R3: In mode 00, the clock after an address phase whose command is 1101 (the upper address half) is dropped. The lower address and every completed data phase are still stored.
- R4: In mode 01, the clock right after every address phase is stored. It carries tag 2 (upper address half) when the address command was 1101. Otherwise it carries tag 3 (wait), or tag 4 if a data transfer completes on that clock.
- R5: In mode 10, every clock is stored. A clock with FRAME# and IRDY# both high is tagged 0 (idle). A clock where STOP# is low and no data transfers is tagged 5 (termination). Any other clock inside a transaction with no transfer is tagged 3 (wait).
- R6: Tag 1 (address) marks a clock where FRAME# is low and the previous clock had both FRAME# and IRDY# high. On tags 1 and 2, `st_aux` equals C/BE#[3:0] exactly as sampled.
- R7: On tag 4 (data), bit i of `st_aux` is 1 exactly when C/BE#[i] is low, meaning byte lane i is valid. For example, 1110 gives 0001, 1100 gives 0011, 0011 gives 1100, 0000 gives 1111, and 1111 gives 0000.
- R8: A stored sample whose clock saw the bus reset input low carries tag 6 (reset), whatever the other signals are. Such a clock is never treated as an address phase.
- R9: A 32-bit timestamp counts every clock. Each stored sample carries the count of the clock on which it was sampled, so the difference between two samples equals the number of clocks between them.
- R10: A change on `mode_req` takes effect only after a clock on which FRAME# and IRDY# are both high. The clock after that idle one is the first to use the new policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; rising edge only |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| bus_rst_n | input | 1 | Bus reset line as observed (active low) |
| ad | input | 32 | Multiplexed address/data lines |
| cbe_n | input | 4 | Command / byte enables, active low |
| frame_n | input | 1 | Transaction frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Target claim, active low |
| stop_n | input | 1 | Target stop request, active low |
| mode_req | input | 2 | Capture policy: 00 bus-cycle, 01 dual-address, 10 every-edge, 11 as 00 |
| st_valid | output | 1 | Store strobe; sink must take the sample this clock |
| st_word | output | 32 | Captured address/data word |
| st_tag | output | 3 | Phase tag: 0 idle, 1 addr, 2 upper addr, 3 wait, 4 data, 5 termination, 6 reset |
| st_aux | output | 4 | Command on tags 1/2, byte-lane mask on tag 4, else zero |
| st_time | output | 32 | Timestamp of the sampled clock |

## Verification
Every result is due one clock after the edge that sampled the bus. The bench drives on falling edges and inspects outputs on falling edges, so a value driven in bench cycle c appears in cycle c+2 of its counter. A falling-edge monitor logs each strobe together with the cycle it saw. One check compares that logged cycle against the driving cycle plus two, and other checks compare timestamp differences against the number of driven clocks. Mode changes are checked by counting the idle clocks the bench drives before the new policy shows in the log.

// File: rtl/pcq_pkg.sv
package pcq_pkg;

  typedef enum logic [2:0] {
    TAG_IDLE  = 3'd0,
    TAG_ADDR  = 3'd1,
    TAG_DACHI = 3'd2,
    TAG_WAIT  = 3'd3,
    TAG_DATA  = 3'd4,
    TAG_TERM  = 3'd5,
    TAG_RESET = 3'd6
  } pcq_tag_e;

  typedef enum logic [1:0] {
    MODE_BUS   = 2'd0,
    MODE_DUAL  = 2'd1,
    MODE_EVERY = 2'd2,
    MODE_RSVD  = 2'd3
  } pcq_mode_e;

  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_DUAL_ADDR = 4'b1101;

endpackage

// File: rtl/pcq_sampler.sv
// Input register stage plus free-running timestamp.
module pcq_sampler #(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8,
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_rst_n,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            devsel_n,
  input  logic            stop_n,
  output logic [AD_W-1:0] s_ad,
  output logic [BE_W-1:0] s_cbe_n,
  output logic            s_frame_n,
  output logic            s_irdy_n,
  output logic            s_trdy_n,
  output logic            s_devsel_n,
  output logic            s_stop_n,
  output logic            s_rst_n,
  output logic [TS_W-1:0] s_ts
);

  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q       <= '0;
      s_ts       <= '0;
      s_ad       <= '0;
      s_cbe_n    <= '1;
      s_frame_n  <= 1'b1;
      s_irdy_n   <= 1'b1;
      s_trdy_n   <= 1'b1;
      s_devsel_n <= 1'b1;
      s_stop_n   <= 1'b1;
      s_rst_n    <= 1'b1;
    end else begin
      ts_q       <= ts_q + 1'b1;
      s_ts       <= ts_q;
      s_ad       <= ad;
      s_cbe_n    <= cbe_n;
      s_frame_n  <= frame_n;
      s_irdy_n   <= irdy_n;
      s_trdy_n   <= trdy_n;
      s_devsel_n <= devsel_n;
      s_stop_n   <= stop_n;
      s_rst_n    <= bus_rst_n;
    end
  end

endmodule

// File: rtl/pcq_classify.sv
// Phase recognition, tagging and the per-mode store decision.
module pcq_classify
  import pcq_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_req,
  input  logic [BE_W-1:0] s_cbe_n,
  input  logic            s_frame_n,
  input  logic            s_irdy_n,
  input  logic            s_trdy_n,
  input  logic            s_devsel_n,
  input  logic            s_stop_n,
  input  logic            s_rst_n,
  output logic            store,
  output pcq_tag_e        tag,
  output logic [BE_W-1:0] aux
);

  pcq_mode_e        mode_q;
  logic             prev_idle_q;
  logic             last_addr_q;
  logic [CMD_W-1:0] last_cmd_q;

  logic            bus_idle;
  logic            is_addr;
  logic            xfer;
  logic            upper_half;
  logic            in_txn;
  logic [BE_W-1:0] lane_ok;

  assign bus_idle   = s_frame_n & s_irdy_n;
  assign is_addr    = s_rst_n & ~s_frame_n & prev_idle_q;
  assign xfer       = ~s_irdy_n & ~s_trdy_n & ~s_devsel_n;
  assign upper_half = last_addr_q & (last_cmd_q == CMD_DUAL_ADDR);
  assign in_txn     = ~bus_idle | last_addr_q;

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign lane_ok[i] = ~s_cbe_n[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_BUS;
      prev_idle_q <= 1'b1;
      last_addr_q <= 1'b0;
      last_cmd_q  <= '1;
    end else begin
      prev_idle_q <= bus_idle;
      last_addr_q <= is_addr;
      if (is_addr) last_cmd_q <= s_cbe_n[CMD_W-1:0];
      if (bus_idle) mode_q <= pcq_mode_e'(mode_req);
    end
  end

  always_comb begin
    if (!s_rst_n)        tag = TAG_RESET;
    else if (is_addr)    tag = TAG_ADDR;
    else if (upper_half) tag = TAG_DACHI;
    else if (xfer)       tag = TAG_DATA;
    else if (!s_stop_n && in_txn) tag = TAG_TERM;
    else if (in_txn)     tag = TAG_WAIT;
    else                 tag = TAG_IDLE;
  end

  always_comb begin
    unique case (mode_q)
      MODE_EVERY: store = 1'b1;
      MODE_DUAL:  store = is_addr | xfer | last_addr_q;
      default:    store = is_addr | xfer;
    endcase
  end

  always_comb begin
    unique case (tag)
      TAG_ADDR, TAG_DACHI: aux = s_cbe_n;
      TAG_DATA:            aux = lane_ok;
      default:             aux = '0;
    endcase
  end

endmodule

// File: rtl/pcq_emit.sv
// Output register stage.
module pcq_emit
  import pcq_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8,
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            store,
  input  pcq_tag_e        tag,
  input  logic [BE_W-1:0] aux,
  input  logic [AD_W-1:0] word,
  input  logic [TS_W-1:0] ts,
  output logic            st_valid,
  output logic [AD_W-1:0] st_word,
  output logic [2:0]      st_tag,
  output logic [BE_W-1:0] st_aux,
  output logic [TS_W-1:0] st_time
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_word  <= '0;
      st_tag   <= TAG_IDLE;
      st_aux   <= '0;
      st_time  <= '0;
    end else begin
      st_valid <= store;
      st_word  <= word;
      st_tag   <= tag;
      st_aux   <= aux;
      st_time  <= ts;
    end
  end

endmodule

// File: rtl/pci_capture_qual.sv
module pci_capture_qual
  import pcq_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int TS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rst_n,
  input  logic [AD_W-1:0]     ad,
  input  logic [AD_W/8-1:0]   cbe_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic                trdy_n,
  input  logic                devsel_n,
  input  logic                stop_n,
  input  logic [1:0]          mode_req,
  output logic                st_valid,
  output logic [AD_W-1:0]     st_word,
  output logic [2:0]          st_tag,
  output logic [AD_W/8-1:0]   st_aux,
  output logic [TS_W-1:0]     st_time
);

  localparam int BE_W = AD_W / 8;

  logic [AD_W-1:0] s_ad;
  logic [BE_W-1:0] s_cbe_n;
  logic            s_frame_n, s_irdy_n, s_trdy_n, s_devsel_n, s_stop_n, s_rst_n;
  logic [TS_W-1:0] s_ts;
  logic            store;
  pcq_tag_e        tag;
  logic [BE_W-1:0] aux;

  pcq_sampler #(.AD_W(AD_W), .BE_W(BE_W), .TS_W(TS_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .ad(ad), .cbe_n(cbe_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .devsel_n(devsel_n),
    .stop_n(stop_n), .s_ad(s_ad), .s_cbe_n(s_cbe_n), .s_frame_n(s_frame_n),
    .s_irdy_n(s_irdy_n), .s_trdy_n(s_trdy_n), .s_devsel_n(s_devsel_n),
    .s_stop_n(s_stop_n), .s_rst_n(s_rst_n), .s_ts(s_ts)
  );

  pcq_classify #(.BE_W(BE_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .s_cbe_n(s_cbe_n),
    .s_frame_n(s_frame_n), .s_irdy_n(s_irdy_n), .s_trdy_n(s_trdy_n),
    .s_devsel_n(s_devsel_n), .s_stop_n(s_stop_n), .s_rst_n(s_rst_n),
    .store(store), .tag(tag), .aux(aux)
  );

  pcq_emit #(.AD_W(AD_W), .BE_W(BE_W), .TS_W(TS_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .store(store), .tag(tag), .aux(aux),
    .word(s_ad), .ts(s_ts), .st_valid(st_valid), .st_word(st_word),
    .st_tag(st_tag), .st_aux(st_aux), .st_time(st_time)
  );

endmodule

// File: rtl/pcq_checker.sv
module pcq_checker
  import pcq_pkg::*;
#(
  parameter int BE_W = 4,
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_rst_n,
  input logic [BE_W-1:0] cbe_n,
  input logic            frame_n,
  input logic            st_valid,
  input logic [2:0]      st_tag,
  input logic [BE_W-1:0] st_aux,
  input logic [TS_W-1:0] st_time
);

  // R9: back-to-back strobes come from back-to-back sampled clocks
  p_time_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && $past(st_valid) |-> (st_time - $past(st_time)) == TS_W'(1));

  // R4: an upper-address sample always follows a stored dual-address command
  p_upper_follows_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_tag == TAG_DACHI |->
      $past(st_valid) && $past(st_tag) == TAG_ADDR && $past(st_aux[3:0]) == CMD_DUAL_ADDR);

  // R8: a sampled bus reset forces the reset tag
  p_reset_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !$past(bus_rst_n, 2) |-> st_tag == TAG_RESET);

  // R7: data samples report inverted byte enables
  p_lane_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_tag == TAG_DATA |-> st_aux == ~$past(cbe_n, 2));

  // R6: an address tag needs FRAME# low and no bus reset on the sampled clock
  p_addr_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_tag == TAG_ADDR |-> !$past(frame_n, 2) && $past(bus_rst_n, 2));

endmodule

bind pci_capture_qual pcq_checker #(.BE_W(AD_W/8), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .cbe_n(cbe_n),
  .frame_n(frame_n), .st_valid(st_valid), .st_tag(st_tag), .st_aux(st_aux),
  .st_time(st_time)
);

// File: tb/tb_pci_capture_qual.sv
module tb_pci_capture_qual;
  import pcq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n, bus_rst_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        frame_n, irdy_n, trdy_n, devsel_n, stop_n;
  logic [1:0]  mode_req;
  logic        st_valid;
  logic [31:0] st_word;
  logic [2:0]  st_tag;
  logic [3:0]  st_aux;
  logic [31:0] st_time;

  always #10 clk = ~clk;

  pci_capture_qual dut (
    .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .ad(ad), .cbe_n(cbe_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .devsel_n(devsel_n),
    .stop_n(stop_n), .mode_req(mode_req), .st_valid(st_valid),
    .st_word(st_word), .st_tag(st_tag), .st_aux(st_aux), .st_time(st_time)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // strobe log
  logic [2:0]  lg_tag  [64];
  logic [31:0] lg_word [64];
  logic [3:0]  lg_aux  [64];
  logic [31:0] lg_time [64];
  int          lg_cyc  [64];
  int          lg_n = 0;
  bit          lg_en = 1'b0;

  always @(negedge clk) begin
    if (lg_en && st_valid && lg_n < 64) begin
      lg_tag[lg_n]  = st_tag;
      lg_word[lg_n] = st_word;
      lg_aux[lg_n]  = st_aux;
      lg_time[lg_n] = st_time;
      lg_cyc[lg_n]  = cyc;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic f, input logic i, input logic t, input logic d,
                     input logic s, input logic [3:0] be, input logic [31:0] a);
    frame_n = f; irdy_n = i; trdy_n = t; devsel_n = d; stop_n = s;
    cbe_n = be; ad = a;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) bus(1, 1, 1, 1, 1, 4'hF, 32'h0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_req = m;
    idle(4);
  endtask

  function automatic int find_tag(input logic [2:0] t);
    for (int k = 0; k < lg_n; k++) if (lg_tag[k] == t) return k;
    return -1;
  endfunction

  function automatic int count_tag(input logic [2:0] t);
    int c = 0;
    for (int k = 0; k < lg_n; k++) if (lg_tag[k] == t) c++;
    return c;
  endfunction

  task automatic t_default_read();
    int c0;
    lg_n = 0;
    c0 = cyc;
    bus(0, 1, 1, 1, 1, 4'b0110, 32'h1000_0040);
    bus(1, 0, 1, 0, 1, 4'b0000, 32'hDEAD_BEEF);
    bus(1, 0, 0, 0, 1, 4'b0000, 32'hCAFE_0001);
    idle(4);
    chk("R2 stored count", lg_n, 2);
    chk("R6 addr tag", lg_tag[0], TAG_ADDR);
    chk("R6 addr command", lg_aux[0], 4'b0110);
    chk("R6 addr word", lg_word[0], 32'h1000_0040);
    chk("R1 latency", lg_cyc[0], c0 + 2);
    chk("R2 data tag", lg_tag[1], TAG_DATA);
    chk("R7 lanes 0000", lg_aux[1], 4'b1111);
    chk("R2 data word", lg_word[1], 32'hCAFE_0001);
    chk("R9 spacing", lg_time[1] - lg_time[0], 2);
  endtask

  task automatic t_dac(input bit dual);
    lg_n = 0;
    bus(0, 1, 1, 1, 1, 4'b1101, 32'h0000_2000);
    bus(0, 1, 1, 1, 1, 4'b0110, 32'h0000_0001);
    bus(1, 0, 0, 0, 1, 4'b1110, 32'h0000_00AA);
    idle(4);
    if (!dual) begin
      chk("R3 upper half dropped", lg_n, 2);
      chk("R3 low addr kept", lg_tag[0], TAG_ADDR);
      chk("R3 data kept", lg_tag[1], TAG_DATA);
      chk("R7 lanes 1110", lg_aux[1], 4'b0001);
    end else begin
      chk("R4 count", lg_n, 3);
      chk("R4 upper tag", lg_tag[1], TAG_DACHI);
      chk("R4 upper word", lg_word[1], 32'h0000_0001);
      chk("R4 data after upper", lg_tag[2], TAG_DATA);
    end
  endtask

  task automatic t_dual_wait();
    lg_n = 0;
    bus(0, 1, 1, 1, 1, 4'b0111, 32'h0000_3000);
    bus(0, 0, 1, 0, 1, 4'b1100, 32'h0000_0BAD);
    bus(0, 0, 0, 0, 1, 4'b1100, 32'h0000_1111);
    bus(0, 0, 0, 0, 1, 4'b0011, 32'h0000_2222);
    bus(1, 0, 0, 0, 1, 4'b1111, 32'h0000_3333);
    idle(4);
    chk("R4 count", lg_n, 5);
    chk("R4 wait tag", lg_tag[1], TAG_WAIT);
    chk("R7 lanes 1100", lg_aux[2], 4'b0011);
    chk("R7 lanes 0011", lg_aux[3], 4'b1100);
    chk("R7 lanes 1111", lg_aux[4], 4'b0000);
    chk("R2 wait before data ignored in count", lg_tag[4], TAG_DATA);
  endtask

  task automatic t_every();
    int k;
    lg_n = 0;
    bus(0, 1, 1, 1, 1, 4'b0010, 32'h0000_0CF8);
    bus(1, 0, 1, 0, 1, 4'b1110, 32'h0);
    bus(1, 0, 1, 0, 0, 4'b1110, 32'h0);
    idle(4);
    k = find_tag(TAG_ADDR);
    chk("R5 addr present", k >= 1, 1);
    if (k >= 1 && k + 3 < lg_n) begin
      chk("R5 idle before", lg_tag[k-1], TAG_IDLE);
      chk("R5 wait", lg_tag[k+1], TAG_WAIT);
      chk("R5 termination", lg_tag[k+2], TAG_TERM);
      chk("R5 idle after", lg_tag[k+3], TAG_IDLE);
      chk("R9 every-edge step", lg_time[k+1] - lg_time[k], 1);
    end
  endtask

  task automatic t_bus_reset();
    int k;
    lg_n = 0;
    bus_rst_n = 1'b0;
    bus(0, 1, 1, 1, 1, 4'b0110, 32'h0000_4000);
    bus_rst_n = 1'b1;
    idle(4);
    k = find_tag(TAG_RESET);
    chk("R8 one reset sample", count_tag(TAG_RESET), 1);
    chk("R8 no address under reset", count_tag(TAG_ADDR), 0);
    if (k >= 0 && k + 1 < lg_n) chk("R8 idle after reset", lg_tag[k+1], TAG_IDLE);
  endtask

  task automatic t_mode_lock();
    lg_n = 0;
    bus(0, 1, 1, 1, 1, 4'b0110, 32'h0000_5000);
    mode_req = 2'b10;
    bus(1, 0, 1, 0, 1, 4'b0000, 32'h0);
    bus(1, 0, 0, 0, 1, 4'b0000, 32'h0000_5555);
    idle(5);
    chk("R10 addr first", lg_tag[0], TAG_ADDR);
    chk("R10 wait not stored mid-transaction", lg_tag[1], TAG_DATA);
    chk("R10 new mode after idle", lg_n >= 3, 1);
    if (lg_n >= 3) chk("R10 idle stored", lg_tag[2], TAG_IDLE);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_rst_n = 1'b1; mode_req = 2'b00;
    frame_n = 1; irdy_n = 1; trdy_n = 1; devsel_n = 1; stop_n = 1;
    cbe_n = 4'hF; ad = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset strobe low", st_valid, 0);
    rst_n = 1'b1;
    lg_en = 1'b1;
    idle(4);
    chk("R2 idle not stored", lg_n, 0);
    t_default_read();
    t_dac(1'b0);
    set_mode(2'b11);
    t_dac(1'b0);
    set_mode(2'b01);
    t_dac(1'b1);
    t_dual_wait();
    set_mode(2'b10);
    t_every();
    t_bus_reset();
    set_mode(2'b00);
    t_mode_lock();
    set_mode(2'b00);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule